// File: doc/BRIEF.md
# Programmable Watchdog Timer with Output Steering

This block watches a processor for loss of control. Software programs one 8-bit control register with a timeout made of a 5-bit multiplier and a 2-bit resolution code. A 16 Hz tick enable drives a countdown. The processor keeps the countdown from reaching zero in one of two ways: it makes any edge on an asynchronous kick input, or it writes the control register. Each of these reloads the full programmed period.

When the count runs out, the watchdog flag is set and a steering bit picks the response. With steering at 0, a level interrupt is raised on a shared output. That output carries a frequency-test waveform when the watchdog does not own it. The interrupt stays up until software writes zero to the control register. With steering at 1, an active-low reset pulse of fixed width is produced. The same event also wipes the control register and four sibling enable bits.

A small register port gives access to three locations. Address 0 is the control register. Address 1 is the flags register, and reading it clears the flag. Address 2 holds the sibling enables.

Top module: `wdog_steer`

## Requirements
- R1: After reset, the control register (address 0) and the sibling enables (address 2) read 0, the flag is 0, `rst_out_n` is 1 and the watchdog is disabled. The control register reads back as written. Its layout is: bit 7 steering, bits 6:2 multiplier, bits 1:0 resolution. Address 3 reads 0.
- R2: The timeout is the multiplier times 1, 4, 16 or 64 ticks of `tick_en`, for resolution codes 00, 01, 10 and 11. The count starts at the write, so writing 8'h0E with a tick on every cycle times out on the 48th tick.
- R3: A rising or a falling edge on `kick_in` reloads the full period. The reload takes effect on the third clock edge after the input changes (two synchronizer flops and one edge flop).
- R4: Any write to the control register reloads the period from the value being written.
- R5: A timeout with steering 1 drives `rst_out_n` low for exactly `PULSE_CYC` clock cycles, starting after the timeout edge. The same timeout clears the control register and `aux_en` (bit 0 frequency test, bit 1 alarm flag enable, bit 2 alarm-in-backup enable, bit 3 square-wave enable).
- R6: A timeout with steering 0 raises the interrupt on `shared_out`. Only a write of 8'h00 to the control register clears it. A nonzero write leaves it set.
- R7: Every timeout sets the flag, seen on `wd_flag` and as bit 7 of address 1. A read of address 1 clears the flag. A timeout in the same cycle as the read wins.
- R8: With a zero multiplier the watchdog never times out, whatever the ticks.
- R9: The watchdog owns `shared_out` while the interrupt is set, or while steering is 0 and the multiplier is nonzero. Otherwise `shared_out` is `ft_wave` gated by `aux_en` bit 0.
- R10: A reload (write or kick edge) in the same cycle as a tick loads the full period, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 16 Hz base tick, one clock wide |
| kick_in | input | 1 | Asynchronous service input, either edge counts |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading address 1 clears the flag) |
| bus_addr | input | 2 | Register select: 0 control, 1 flags, 2 sibling enables |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| ft_wave | input | 1 | Frequency-test waveform to share the output with |
| aux_en | output | 4 | Sibling enable bits |
| wd_flag | output | 1 | Watchdog flag |
| shared_out | output | 1 | Interrupt level or frequency-test waveform |
| rst_out_n | output | 1 | Active-low reset pulse |

## Verification
The hardest case to reach from the ports is the reload and the last tick landing on the same cycle (R10). The stimulus reaches it in two ways. A directed test holds a write of a one-tick period for many cycles while ticks arrive on every cycle, so the reload meets a tick each time. A randomized phase then mixes kick toggles, writes and reads against ticks at varying rates. A timeout at the same moment as a flag read is also hard to line up (R7). Random reads during short periods hit this case, and a reference model checks every output on every clock.

// File: rtl/wdog_pkg.sv
// Shared constants, types and the period computation for the watchdog.
package wdog_pkg;
    localparam int MULT_W  = 5;
    localparam int RES_W   = 2;
    localparam int AUX_W   = 4;
    // Largest load is max multiplier shifted by 2*max resolution code.
    localparam int CNT_W   = MULT_W + 2 * ((1 << RES_W) - 1);

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_FLAGS = 2'd1,
        ADDR_AUX   = 2'd2,
        ADDR_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_ctrl_t;

    // Period in ticks: multiplier times 4**res.
    function automatic logic [CNT_W-1:0] wd_period(input wd_ctrl_t c);
        logic [CNT_W-1:0] m;
        m = {{(CNT_W-MULT_W){1'b0}}, c.mult};
        return m << {c.res, 1'b0};
    endfunction
endpackage

// File: rtl/wdog_kick_sync.sv
// Brings the asynchronous kick input into the clock domain and flags any edge.
// Assumes kick_in may change at any time; the edge pulse is one clock wide.
module wdog_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_in,
    output logic kick_edge
);
    logic [STAGES:0] chain_q;

    // Shift the input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], kick_in};
    end

    assign kick_edge = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/wdog_countdown.sv
// Tick countdown: reloads on restart, decrements on ticks, and reports expiry
// when the last tick is consumed. Assumes a zero load means disabled.
module wdog_countdown import wdog_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             restart,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    // A restart wins over a tick; the count holds at zero once spent.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (restart)                 cnt_q <= load_val;
        else if (tick_en && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expire = tick_en && !restart &&
                    (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/wdog_pulse_gen.sv
// Fixed-width active-low pulse. A trigger (re)starts a pulse of WIDTH cycles.
module wdog_pulse_gen #(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse_n
);
    localparam int PW = $clog2(WIDTH + 1);
    localparam logic [PW-1:0] LOADV = PW'(WIDTH);

    logic [PW-1:0] left_q;

    // Load the width on a trigger, otherwise run down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (trigger)        left_q <= LOADV;
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign pulse_n = (left_q == '0);
endmodule

// File: rtl/wdog_steer.sv
// Watchdog top: control, flag and sibling enable registers, the restart logic,
// the steering of a timeout to an interrupt level or a reset pulse, and the
// sharing of the interrupt output with the frequency-test waveform.
// Assumes tick_en is one clock wide at 16 Hz and reads are single strobes.
module wdog_steer import wdog_pkg::*; #(
    parameter int PULSE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             kick_in,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             ft_wave,
    output logic [AUX_W-1:0] aux_en,
    output logic             wd_flag,
    output logic             shared_out,
    output logic             rst_out_n
);
    localparam int SYNC_STAGES = 2;

    wd_ctrl_t         ctrl_q;
    wd_ctrl_t         wdata_ctrl;
    logic [AUX_W-1:0] aux_q;
    logic             irq_q;
    logic             flag_q;
    logic             wr_ctrl, wr_aux, rd_flags, clr_irq;
    logic             kick_edge, restart, expire, reset_hit;
    logic             wd_owns;
    logic [CNT_W-1:0] load_val;

    assign wdata_ctrl = wd_ctrl_t'(bus_wdata);
    assign wr_ctrl    = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_aux     = bus_wr && (bus_addr == ADDR_AUX);
    assign rd_flags   = bus_rd && (bus_addr == ADDR_FLAGS);
    assign clr_irq    = wr_ctrl && (bus_wdata == 8'h00);
    assign restart    = wr_ctrl || kick_edge;
    assign load_val   = wr_ctrl ? wd_period(wdata_ctrl) : wd_period(ctrl_q);
    assign reset_hit  = expire && ctrl_q.steer;

    wdog_kick_sync #(.STAGES(SYNC_STAGES)) i_kick (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick_in   (kick_in),
        .kick_edge (kick_edge)
    );

    wdog_countdown i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .restart  (restart),
        .load_val (load_val),
        .expire   (expire)
    );

    wdog_pulse_gen #(.WIDTH(PULSE_CYC)) i_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (reset_hit),
        .pulse_n (rst_out_n)
    );

    // Control register: software write, wiped by a reset-steered timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (wr_ctrl)   ctrl_q <= wdata_ctrl;
        else if (reset_hit) ctrl_q <= '0;
    end

    // Sibling enables: software write, wiped by a reset-steered timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)         aux_q <= '0;
        else if (wr_aux)    aux_q <= bus_wdata[AUX_W-1:0];
        else if (reset_hit) aux_q <= '0;
    end

    // Interrupt level: set by an interrupt-steered timeout, cleared by a zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)                        irq_q <= 1'b0;
        else if (clr_irq)                  irq_q <= 1'b0;
        else if (expire && !ctrl_q.steer)  irq_q <= 1'b1;
    end

    // Watchdog flag: set on any timeout, which beats a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (expire)   flag_q <= 1'b1;
        else if (rd_flags) flag_q <= 1'b0;
    end

    // Output sharing: an armed interrupt-steered watchdog suppresses frequency test.
    assign wd_owns    = irq_q || (!ctrl_q.steer && ctrl_q.mult != '0);
    assign shared_out = wd_owns ? irq_q : (aux_q[0] && ft_wave);

    // Read mux for the register port.
    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:  bus_rdata = ctrl_q;
            ADDR_FLAGS: bus_rdata = {flag_q, 7'b0};
            ADDR_AUX:   bus_rdata = {{(8-AUX_W){1'b0}}, aux_q};
            default:    bus_rdata = 8'h00;
        endcase
    end

    assign aux_en  = aux_q;
    assign wd_flag = flag_q;
endmodule

// File: rtl/wdog_steer_chk.sv
// Property checker for the watchdog top, attached with bind.
module wdog_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       expire,
    input logic [7:0] ctrl_q,
    input logic       irq_q,
    input logic       clr_irq,
    input logic       rd_flags,
    input logic       wd_flag,
    input logic       rst_out_n,
    input logic [3:0] aux_en
);
    AST_PULSE_ON_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        expire && ctrl_q[7] |=> !rst_out_n) else $error("pulse missing"); // R5

    AST_CTRL_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
        expire && ctrl_q[7] |=> (ctrl_q == 8'h00) && (aux_en == 4'h0)) else $error("wipe missing"); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !clr_irq |=> irq_q) else $error("irq dropped"); // R6

    AST_FLAG_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> wd_flag) else $error("flag not set"); // R7

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wd_flag && !rd_flags |=> wd_flag) else $error("flag dropped"); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[6:2] == 5'd0) |-> !expire) else $error("expiry while disabled"); // R8
endmodule

bind wdog_steer wdog_steer_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .ctrl_q    (ctrl_q),
    .irq_q     (irq_q),
    .clr_irq   (clr_irq),
    .rd_flags  (rd_flags),
    .wd_flag   (wd_flag),
    .rst_out_n (rst_out_n),
    .aux_en    (aux_en)
);

// File: tb/test_wdog_steer.sv
`timescale 1ns/1ps
module test_wdog_steer;
    localparam int PULSE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       kick_in = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ft_wave = 1'b0;
    logic [3:0] aux_en;
    logic       wd_flag, shared_out, rst_out_n;

    int checks = 0;
    int fails = 0;
    bit cmp_on = 0;
    bit tick_on = 0;
    int tick_div = 1;
    int tcnt = 0;

    always #5 clk = ~clk;

    wdog_steer #(.PULSE_CYC(PULSE)) i_wdog_steer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .kick_in(kick_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ft_wave(ft_wave),
        .aux_en(aux_en), .wd_flag(wd_flag), .shared_out(shared_out),
        .rst_out_n(rst_out_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ctrl, m_aux, m_cnt, m_flag, m_irq, m_pulse;
    int kq[$];

    function automatic int period_of(input int v);
        return ((v >> 2) & 31) * (1 << (2 * (v & 3)));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_aux = 0; m_cnt = 0; m_flag = 0; m_irq = 0; m_pulse = 0;
            kq = {0, 0, 0};
        end else begin
            int  wr_c, wr_a, rd_f, kedge, rs, exp_now, stv;
            wr_c  = bus_wr && bus_addr == 0;
            wr_a  = bus_wr && bus_addr == 2;
            rd_f  = bus_rd && bus_addr == 1;
            kedge = (kq[1] != kq[2]);
            rs    = wr_c || kedge;
            exp_now = !rs && tick_en && m_cnt == 1;
            stv   = (m_ctrl >> 7) & 1;
            // pulse
            if (exp_now && stv) m_pulse = PULSE;
            else if (m_pulse > 0) m_pulse--;
            // counter
            if (rs) m_cnt = period_of(wr_c ? int'(bus_wdata) : m_ctrl);
            else if (tick_en && m_cnt > 0) m_cnt--;
            // irq
            if (wr_c && bus_wdata == 0) m_irq = 0;
            else if (exp_now && !stv) m_irq = 1;
            // flag
            if (exp_now) m_flag = 1;
            else if (rd_f) m_flag = 0;
            // registers
            if (wr_c) m_ctrl = bus_wdata;
            else if (exp_now && stv) m_ctrl = 0;
            if (wr_a) m_aux = bus_wdata & 15;
            else if (exp_now && stv) m_aux = 0;
            kq.push_front(int'(kick_in));
            void'(kq.pop_back());
        end
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            int owns, exp_sh, exp_rd;
            owns   = m_irq || (((m_ctrl >> 7) & 1) == 0 && ((m_ctrl >> 2) & 31) != 0);
            exp_sh = owns ? m_irq : ((m_aux & 1) && ft_wave);
            case (bus_addr)
                2'd0: exp_rd = m_ctrl;
                2'd1: exp_rd = m_flag << 7;
                2'd2: exp_rd = m_aux;
                default: exp_rd = 0;
            endcase
            chk("R1", "model bus_rdata", int'(bus_rdata), exp_rd);
            chk("R5", "model rst_out_n", int'(rst_out_n), (m_pulse > 0) ? 0 : 1);
            chk("R5", "model aux_en", int'(aux_en), m_aux);
            chk("R7", "model wd_flag", int'(wd_flag), m_flag);
            chk("R9", "model shared_out", int'(shared_out), exp_sh);
        end
    end

    // Tick generator driven away from the edge.
    always @(posedge clk) begin
        #2;
        tcnt++;
        tick_en = tick_on && (tcnt % tick_div == 0);
    end

    task automatic wr_reg(input int a, input int d);
        @(posedge clk); #2;
        bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a);
        @(posedge clk); #2;
        bus_addr = 2'(a); bus_rd = 1'b1;
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic clear_all();
        wr_reg(0, 8'h00);
        rd_reg(1);
    endtask

    // Watchdog on the run itself.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lows;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);
        // R1: reset state
        bus_addr = 2'd0; #1;
        chk("R1", "reset ctrl", int'(bus_rdata), 0);
        chk("R1", "reset flag", int'(wd_flag), 0);
        chk("R1", "reset rst_out_n", int'(rst_out_n), 1);
        chk("R1", "reset aux", int'(aux_en), 0);

        // R1 readback and R2 timing with a tick on every cycle
        tick_div = 1; tick_on = 1;
        wr_reg(0, 8'h0E);
        repeat (48) @(negedge clk);
        chk("R1", "ctrl readback", int'(bus_rdata), 8'h0E);
        chk("R2", "no timeout after 47 ticks", int'(shared_out), 0);
        @(negedge clk);
        chk("R2", "timeout on 48th tick", int'(shared_out), 1);

        // R7: flag visible then cleared by reading
        @(posedge clk); #2 bus_addr = 2'd1;
        @(negedge clk);
        chk("R7", "flag bit 7 set", int'(bus_rdata), 8'h80);
        rd_reg(1);
        @(negedge clk);
        chk("R7", "flag cleared by read", int'(bus_rdata), 0);

        // R6: nonzero write keeps the interrupt, zero write clears it
        wr_reg(0, 8'h0D);
        @(negedge clk);
        chk("R6", "irq kept after nonzero write", int'(shared_out), 1);
        wr_reg(0, 8'h00);
        @(negedge clk);
        chk("R6", "irq cleared by zero write", int'(shared_out), 0);
        rd_reg(1);

        // R3/R4: kicks on both edges hold off a 16-tick period
        wr_reg(0, 8'h06);
        for (int i = 0; i < 8; i++) begin
            repeat (8) @(posedge clk);
            #2 kick_in = ~kick_in;
        end
        @(negedge clk);
        chk("R3", "kicked watchdog quiet", int'(shared_out), 0);
        chk("R3", "kicked watchdog no flag", int'(wd_flag), 0);
        repeat (30) @(negedge clk);
        chk("R3", "unkicked watchdog fires", int'(shared_out), 1);
        clear_all();

        // R10: a reload on every tick cycle never lets a one-tick period expire
        @(posedge clk); #2;
        bus_addr = 2'd0; bus_wdata = 8'h04; bus_wr = 1'b1;
        repeat (20) @(posedge clk);
        #2 bus_wr = 1'b0;
        @(negedge clk);
        chk("R10", "reload beats tick", int'(wd_flag), 0);
        repeat (3) @(negedge clk);
        chk("R10", "expires after reloads stop", int'(wd_flag), 1);
        clear_all();

        // R8: zero multiplier is disabled
        wr_reg(0, 8'h03);
        repeat (200) @(negedge clk);
        chk("R8", "disabled no flag", int'(wd_flag), 0);
        chk("R8", "disabled no irq", int'(shared_out), 0);

        // R9: frequency test shares the output unless the watchdog owns it
        tick_on = 0;
        wr_reg(2, 8'h01);
        wr_reg(0, 8'h00);
        @(posedge clk); #2 ft_wave = 1'b1;
        @(negedge clk);
        chk("R9", "ft passes when free", int'(shared_out), 1);
        @(posedge clk); #2 ft_wave = 1'b0;
        @(negedge clk);
        chk("R9", "ft low passes", int'(shared_out), 0);
        wr_reg(0, 8'h05);
        @(posedge clk); #2 ft_wave = 1'b1;
        @(negedge clk);
        chk("R9", "ft suppressed when owned", int'(shared_out), 0);
        wr_reg(0, 8'h00);

        // R5: reset-steered timeout wipes registers and pulses
        ft_wave = 1'b0;
        wr_reg(2, 8'h0F);
        tick_div = 1; tick_on = 1;
        wr_reg(0, 8'h85);
        bus_addr = 2'd0;
        lows = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!rst_out_n) lows++;
            if (i == 4) begin
                chk("R5", "pulse starts", int'(rst_out_n), 0);
                chk("R5", "ctrl wiped", int'(bus_rdata), 0);
                chk("R5", "siblings wiped", int'(aux_en), 0);
            end
        end
        chk("R5", "pulse width", lows, PULSE);
        rd_reg(1);

        // Randomised mix checked by the model every clock
        for (int blk = 0; blk < 10; blk++) begin
            tick_div = 1 + int'($urandom % 4);
            for (int i = 0; i < 200; i++) begin
                int r;
                @(posedge clk); #3;
                r = int'($urandom % 100);
                bus_wr = (r < 6);
                bus_rd = (r >= 6 && r < 14);
                bus_addr = 2'($urandom % 4);
                bus_wdata = 8'($urandom);
                if (bus_addr == 2'd0) bus_wdata[6:4] = 3'b000;
                if (r > 94) kick_in = ~kick_in;
                ft_wave = 1'($urandom % 2);
            end
        end
        @(posedge clk); #3 bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (5) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule